// File: doc/BRIEF.md
# Streaming Separable 2-D Convolver

This block filters a greyscale frame that arrives in raster order, one signed Q15 pixel per beat on a valid/ready stream. It applies a 1-D filter along each row with one tap set, keeps only the most recent K row results in a circular row store, and then filters down each column of that store with a second tap set. Finished pixels leave on a second valid/ready stream one complete row at a time, with markers for the end of each row and the end of the frame.

Both tap sets are written through a small register port while the block is idle. A busy flag shows that a frame is in progress, and a sticky overflow flag records any result that had to be clipped. Frame width, frame height and the odd kernel length are parameters.

The datapath has one multiplier. Each pass spends one cycle per tap per pixel, and the input stream is held off through ready while the block computes or emits. Once the last input row is in, the bottom rows of output are produced from the held window with no further input.

Top module: `sep_conv2d`

## Requirements
- R1: The row pass computes, for pixel (y,x), the sum over i=0..K-1 of pixel(y, clamp(x+i-r)) times row tap i, with r=K/2. Columns outside 0..W-1 are clamped to the nearest edge column.
- R2: The column pass computes the output (y,x) as the sum over i of the row-pass result at (clamp(y+i-r), x) times column tap i. Rows outside 0..H-1 are clamped to the nearest edge row. Outputs leave in raster order.
- R3: Each pass sums 16x16 signed products in a 32-bit signed accumulator that wraps, and then forms (acc + 16384) >>> 15, which rounds half upward. A value of -1 at a gain of one half therefore gives 0, not -1.
- R4: A rounded value above 32767 becomes 32767, and one below -32768 becomes -32768. Either case sets `ovf`, which stays at 1 until a cycle with `ovf_clr` high.
- R5: `o_eol` is 1 on the last pixel (x=W-1) of every output row. `o_eof` is 1 only on the final pixel of the frame.
- R6: While `o_valid` is 1 and `o_ready` is 0, `o_valid`, `o_data` and the markers hold their values.
- R7: `i_ready` is 0 whenever an output beat is pending or a pass is computing. No accepted pixel is lost under any pattern of gaps on either stream.
- R8: `busy` is 1 from the first accepted pixel of a frame until the last output beat has been taken. A tap write (`cfg_vert` 0 selects the row taps, 1 selects the column taps; `cfg_idx` is the tap index) has no effect while `busy` is 1.
- R9: After reset `o_valid`=0, `busy`=0, `ovf`=0 and `i_ready`=1.
- R10: Frames may follow one another with no gap, and each is filtered independently of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Input pixel valid |
| i_ready | output | 1 | Block can take an input pixel |
| i_data | input | 16 | Input pixel, signed Q15 |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Consumer takes the output pixel |
| o_data | output | 16 | Filtered pixel, signed Q15 |
| o_eol | output | 1 | Last pixel of an output row |
| o_eof | output | 1 | Last pixel of the frame |
| cfg_we | input | 1 | Tap write strobe |
| cfg_vert | input | 1 | 0 selects the row taps, 1 selects the column taps |
| cfg_idx | input | $clog2(K) | Tap index |
| cfg_data | input | 16 | Tap value, signed Q15 |
| busy | output | 1 | Frame in progress |
| ovf | output | 1 | Sticky saturation flag |
| ovf_clr | input | 1 | Clears `ovf` |

## Verification
The bench targets the border pixels, where clamping must replicate the edge row or column. A wrong clamp index shifts or zeroes the outermost r rows and columns, and a wrong drain rule hangs the run or emits the bottom rows too early. It drives odd pixels at a gain of one half to separate round-half-up from truncation, which would give -1 where 0 is expected. Full-scale frames must clip to the rails and leave the sticky flag set until it is cleared; a design without saturation would wrap its signs instead. A row-tap write made mid-frame must leave the results unchanged, and random gaps on both streams expose lost or duplicated beats.

// File: rtl/sep_conv2d.sv
module sep_conv2d #(
  parameter int W = 64,
  parameter int H = 64,
  parameter int K = 15,
  localparam int TW = $clog2(K)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_valid,
  output logic                 i_ready,
  input  logic signed [15:0]   i_data,
  output logic                 o_valid,
  input  logic                 o_ready,
  output logic signed [15:0]   o_data,
  output logic                 o_eol,
  output logic                 o_eof,
  input  logic                 cfg_we,
  input  logic                 cfg_vert,
  input  logic [TW-1:0]        cfg_idx,
  input  logic signed [15:0]   cfg_data,
  output logic                 busy,
  output logic                 ovf,
  input  logic                 ovf_clr
);
  localparam int R = K / 2;

  typedef enum logic [2:0] {S_IN, S_H, S_DEC, S_V, S_OUT} st_t;
  st_t st;

  logic signed [15:0] raw  [W];
  logic signed [15:0] win  [K*W];
  logic signed [15:0] htap [K];
  logic signed [15:0] vtap [K];

  int ix, hx, vx, oy, hn, ti;
  int hcol, vrow, vaddr, waddr;
  logic signed [31:0] acc, prod, sum;
  logic signed [15:0] mul_a, mul_b, res;
  logic signed [32:0] rnd, sh;
  logic clip, can_emit, last_tap;

  always_comb begin
    hcol = hx + ti - R;
    if (hcol < 0) hcol = 0;
    if (hcol > W-1) hcol = W-1;
    vrow = oy + ti - R;
    if (vrow < 0) vrow = 0;
    if (vrow > H-1) vrow = H-1;
    vaddr = (vrow % K) * W + vx;
    waddr = (hn % K) * W + hx;
  end

  assign mul_a    = (st == S_H) ? raw[hcol] : win[vaddr];
  assign mul_b    = (st == S_H) ? htap[ti] : vtap[ti];
  assign prod     = mul_a * mul_b;
  assign sum      = acc + prod;
  assign rnd      = {sum[31], sum} + 33'sd16384;
  assign sh       = rnd >>> 15;
  assign clip     = (sh > 33'sd32767) || (sh < -33'sd32768);
  assign res      = (sh > 33'sd32767) ? 16'sh7fff : (sh < -33'sd32768) ? 16'sh8000 : sh[15:0];
  assign last_tap = (ti == K-1);
  assign can_emit = (oy < H) && (((oy + R < H) ? oy + R : H-1) < hn);
  assign i_ready  = (st == S_IN);
  assign busy     = !(st == S_IN && ix == 0 && hn == 0);

  always_ff @(posedge clk) begin
    if (st == S_IN && i_valid) raw[ix] <= i_data;
    if (st == S_H && last_tap) win[waddr] <= res;
    if (cfg_we && !busy) begin
      if (cfg_vert) vtap[cfg_idx] <= cfg_data;
      else          htap[cfg_idx] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IN;
      {ix, hx, vx, oy, hn, ti} <= '0;
      acc <= '0;
      o_valid <= 1'b0;
      o_data <= '0;
      o_eol <= 1'b0;
      o_eof <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (ovf_clr) ovf <= 1'b0;
      case (st)
        S_IN: if (i_valid) begin
          if (ix == W-1) begin ix <= 0; st <= S_H; end
          else ix <= ix + 1;
        end
        S_H: if (last_tap) begin
          acc <= '0;
          ti <= 0;
          if (clip) ovf <= 1'b1;
          if (hx == W-1) begin hx <= 0; hn <= hn + 1; st <= S_DEC; end
          else hx <= hx + 1;
        end else begin
          acc <= sum;
          ti <= ti + 1;
        end
        S_DEC: begin
          if (can_emit) st <= S_V;
          else begin
            st <= S_IN;
            if (hn == H) begin hn <= 0; oy <= 0; end
          end
        end
        S_V: if (last_tap) begin
          acc <= '0;
          ti <= 0;
          if (clip) ovf <= 1'b1;
          o_valid <= 1'b1;
          o_data <= res;
          o_eol <= (vx == W-1);
          o_eof <= (vx == W-1) && (oy == H-1);
          st <= S_OUT;
        end else begin
          acc <= sum;
          ti <= ti + 1;
        end
        S_OUT: if (o_ready) begin
          o_valid <= 1'b0;
          if (vx == W-1) begin vx <= 0; oy <= oy + 1; st <= S_DEC; end
          else begin vx <= vx + 1; st <= S_V; end
        end
        default: st <= S_IN;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_eol) && $stable(o_eof)); // R6
  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !i_ready); // R7
  AST_EOF_ON_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_eof |-> o_eol); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R4
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid && i_ready |=> busy); // R8
endmodule

// File: tb/tb_sep_conv2d.sv
module tb_sep_conv2d;
  localparam int W = 7, H = 6, K = 5, R = K / 2, TW = $clog2(K);

  logic clk = 0, rst_n = 0;
  logic i_valid = 0, o_ready = 0, cfg_we = 0, cfg_vert = 0, ovf_clr = 0;
  logic signed [15:0] i_data = 0, cfg_data = 0;
  logic [TW-1:0] cfg_idx = 0;
  logic i_ready, o_valid, o_eol, o_eof, busy, ovf;
  logic signed [15:0] o_data;

  sep_conv2d #(.W(W), .H(H), .K(K)) dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready), .i_data(i_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_eol(o_eol), .o_eof(o_eof),
    .cfg_we(cfg_we), .cfg_vert(cfg_vert), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .busy(busy), .ovf(ovf), .ovf_clr(ovf_clr));

  always #2.5 clk = ~clk;

  shortint pix [H][W];
  shortint ht [K], vt [K];
  shortint expo [H][W];
  bit m_ovf;
  int checks = 0, fails = 0;
  bit wd = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic shortint rs(int acc);
    longint t = (longint'(acc) + 16384) >>> 15;
    if (t > 32767) begin m_ovf = 1; return 16'sh7fff; end
    if (t < -32768) begin m_ovf = 1; return 16'sh8000; end
    return shortint'(t);
  endfunction

  function automatic int clampi(int v, int hi);
    return v < 0 ? 0 : (v > hi ? hi : v);
  endfunction

  function automatic void model();
    shortint hr [H][W];
    m_ovf = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int acc = 0;
        for (int i = 0; i < K; i++) acc += int'(pix[y][clampi(x+i-R, W-1)]) * int'(ht[i]);
        hr[y][x] = rs(acc);
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int acc = 0;
        for (int i = 0; i < K; i++) acc += int'(hr[clampi(y+i-R, H-1)][x]) * int'(vt[i]);
        expo[y][x] = rs(acc);
      end
  endfunction

  task automatic wtap(bit vert, int idx, shortint d);
    @(negedge clk);
    cfg_we = 1; cfg_vert = vert; cfg_idx = TW'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    if (vert) vt[idx] = d; else ht[idx] = d;
  endtask

  task automatic run_frame(string req, int vgap, int rgap, bit poke);
    model();
    fork
      begin
        int idx = 0;
        bit poked = 0;
        while (idx < H*W) begin
          @(negedge clk);
          cfg_we = 0;
          i_valid = (($urandom % 100) >= vgap);
          i_data = pix[idx/W][idx%W];
          if (poke && !poked && idx == 3) begin
            cfg_we = 1; cfg_vert = 0; cfg_idx = TW'(R); cfg_data = 16'sd0; poked = 1;
            chk(busy == 1'b1, "R8 busy mid-frame", int'(busy), 1);
          end
          if (i_valid && i_ready) idx++;
        end
        @(negedge clk);
        i_valid = 0; cfg_we = 0;
      end
      begin
        int n = 0;
        while (n < H*W) begin
          @(negedge clk);
          o_ready = (($urandom % 100) >= rgap);
          if (o_valid && o_ready) begin
            int y = n / W, x = n % W;
            chk(o_data == expo[y][x], req, int'(o_data), int'(expo[y][x]));
            chk(o_eol == (x == W-1), "R5 eol", int'(o_eol), int'(x == W-1));
            chk(o_eof == (n == H*W-1), "R5 eof", int'(o_eof), int'(n == H*W-1));
            n++;
          end
        end
        @(negedge clk);
        o_ready = 0;
      end
    join
  endtask

  task automatic rand_frame(int amp);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        pix[y][x] = shortint'(int'($urandom % (2*amp+1)) - amp);
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(o_valid == 1'b0, "R9 o_valid", int'(o_valid), 0);
    chk(busy == 1'b0, "R9 busy", int'(busy), 0);
    chk(ovf == 1'b0, "R9 ovf", int'(ovf), 0);
    chk(i_ready == 1'b1, "R9 i_ready", int'(i_ready), 1);
    rst_n = 1;

    for (int i = 0; i < K; i++) wtap(0, i, shortint'(int'($urandom % 12001) - 6000));
    for (int i = 0; i < K; i++) wtap(1, i, (i == R) ? 16'sh7fff : 16'sd0);
    rand_frame(20000);
    run_frame("R1 row pass", 30, 30, 0);

    for (int i = 0; i < K; i++) wtap(1, i, shortint'(int'($urandom % 12001) - 6000));
    rand_frame(32767);
    run_frame("R2 both passes", 0, 0, 0);
    rand_frame(32767);
    run_frame("R10 R7 back-pressure frame", 60, 60, 0);

    for (int i = 0; i < K; i++) wtap(0, i, (i == R) ? 16'sd16384 : 16'sd0);
    for (int i = 0; i < K; i++) wtap(1, i, (i == R) ? 16'sd16384 : 16'sd0);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) pix[y][x] = shortint'(((x + y) % 2 == 0) ? -1 : 3);
    run_frame("R3 rounding", 10, 10, 0);
    chk(expo[0][0] == 16'sd0, "R3 bench value", int'(expo[0][0]), 0);

    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    for (int i = 0; i < K; i++) wtap(0, i, 16'sd12000);
    for (int i = 0; i < K; i++) wtap(1, i, (i == R) ? 16'sh7fff : 16'sd0);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) pix[y][x] = (y < H/2) ? 16'sh7fff : 16'sh8000;
    run_frame("R4 saturation", 0, 20, 0);
    @(negedge clk);
    chk(ovf == 1'b1, "R4 ovf set", int'(ovf), 1);
    chk(m_ovf == 1'b1, "R4 bench clip", int'(m_ovf), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk(ovf == 1'b0, "R4 ovf cleared", int'(ovf), 0);

    for (int i = 0; i < K; i++) wtap(0, i, shortint'(int'($urandom % 12001) - 6000));
    for (int i = 0; i < K; i++) wtap(1, i, shortint'(int'($urandom % 12001) - 6000));
    rand_frame(30000);
    run_frame("R8 tap write ignored", 20, 20, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8 idle after frame", int'(busy), 0);

    wtap(0, R, 16'sd0);
    rand_frame(30000);
    run_frame("R8 idle tap write applied", 20, 20, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule